// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block controls sixteen general-purpose pins through a byte-wide register port. Each pin owns two configuration bytes. One drives the pad: direction, output level, open-drain versus push-pull, and the pull-resistor enable and strength code, which go straight out to the pad cell. The other selects which input edges raise an interrupt, and it reads back the synchronized pad level.

The pins form banks of eight. Pin n reports to bank n/8 at bit n%8. Each bank holds a write-one-to-clear pending byte, a primary mask byte and a secondary mask byte. The secondary mask is storage only, kept for a low-power state, and has no effect here. The host sees one level-sensitive interrupt line. It is the OR of all pending bits whose primary mask bit is clear.

Top module: `gpio_edge_ctl`

## Requirements
- R1: After reset every pad output enable is 0, every edge mode is 0, every primary and secondary mask byte reads 0xFF, every pending byte reads 0x00 and `irq` is 0.
- R2: The pad-control byte of pin n sits at 0x2B+(n%8)+0x10*(n/8). Its edge-control byte sits at 0x33+(n%8)+0x10*(n/8).
- R3: The pad-control byte is laid out as bit 5 direction (1 = drive), bit 4 open-drain, bit 3 pull enable, bits 2:1 pull code and bit 0 output level. Bits 7:6 read 0. Each field drives its pad pin directly, with one exception: `pad_oe` is direction AND NOT (open-drain AND level), so an open-drain pin releases the pad when the level is high.
- R4: In the edge-control byte, bits 2:1 are the edge mode and read back as written. Bit 0 reads the pad level after a two-flop synchronizer. Bits 7:3 read 0.
- R5: Edge mode 1 flags falling edges, 2 flags rising edges and 3 flags both. A flagged edge on pin n sets bit n%8 of the pending byte of bank n/8, at 0x0B for bank 0 and 0x0C for bank 1, within four clocks of the pad change.
- R6: With edge mode 0 a pin never sets its pending bit, however it toggles.
- R7: Writing a pending byte clears exactly the bits written as 1 and leaves bits written as 0 unchanged.
- R8: When an edge is flagged in the same cycle that a write clears that pending bit, the bit stays set.
- R9: The primary mask bytes sit at 0x19 and 0x1A, where 1 masks and 0 unmasks. `irq` is 1 exactly while some pending bit has its primary mask bit at 0.
- R10: The secondary mask bytes at 0x1B and 0x1C read back as written and do not change `irq`.
- R11: Read data is registered and appears on `rdata` in the cycle after `rd_en`. It holds otherwise. A read of any address not listed above returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output levels |
| pad_oe | output | 16 | Pad output enables |
| pad_od | output | 16 | Open-drain select per pad |
| pad_pull_en | output | 16 | Pull-resistor enable per pad |
| pad_pull_sel | output | 32 | Pull code, two bits per pad, pin n at [2n+1:2n] |
| irq | output | 1 | Combined level interrupt to the host |

## Verification
A wrong bank or bit index in the pending logic shows as a bit set in the wrong pending byte, read back four clocks after the pad toggles. It also shows as `irq` asserting or staying low against the mask written. A corrupted edge mode either sets pending on the wrong polarity or fails to set it on the right one, within the same window. A faulty clear path shows on the next pending read. The race between a clear write and a new edge is placed on the exact cycle the edge is latched, so losing the edge leaves the bit at 0 on the following read.

// File: rtl/gpio_edge_ctl_pkg.sv
// Package: shared sizes and register address bases for the GPIO controller.
// Assumes banks are spaced 0x10 apart in the control-byte region.
package gpio_edge_ctl_pkg;
    parameter int PINS_PER_BANK = 8;
    parameter int NUM_BANKS     = 2;
    localparam int NUM_PINS     = PINS_PER_BANK * NUM_BANKS;

    localparam logic [7:0] PAD_CTL_BASE  = 8'h2B;
    localparam logic [7:0] EDGE_CTL_BASE = 8'h33;
    localparam logic [7:0] BANK_STRIDE   = 8'h10;
    localparam logic [7:0] PEND_BASE     = 8'h0B;
    localparam logic [7:0] MASK_BASE     = 8'h19;
    localparam logic [7:0] MASKX_BASE    = 8'h1B;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_RISE = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_t;
endpackage

// File: rtl/gpio_pin_slice.sv
// Module: one pin's pad-control and edge-control state, plus its input
// synchronizer and edge detector.
// Assumes pad_in is asynchronous to clk; evt_o pulses for one cycle per edge.
module gpio_pin_slice
    import gpio_edge_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_pad,
    input  logic       wr_edge,
    input  logic [5:0] wdata,
    input  logic       pad_in,
    output logic [5:0] pad_ctl_o,
    output logic [2:0] edge_ctl_o,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       pad_od,
    output logic       pull_en,
    output logic [1:0] pull_sel,
    output logic       evt_o
);
    logic [5:0]  pad_ctl_q;
    edge_mode_t  mode_q;
    logic [2:0]  sync_q;

    // Pad-control byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)      pad_ctl_q <= '0;
        else if (wr_pad) pad_ctl_q <= wdata;
    end

    // Edge-mode field storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= EDGE_OFF;
        else if (wr_edge) mode_q <= edge_mode_t'(wdata[2:1]);
    end

    // Two-flop synchronizer plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], pad_in};
    end

    // Pad drive decode; open-drain releases the pad on a high level.
    always_comb begin
        pad_out  = pad_ctl_q[0];
        pull_sel = pad_ctl_q[2:1];
        pull_en  = pad_ctl_q[3];
        pad_od   = pad_ctl_q[4];
        pad_oe   = pad_ctl_q[5] & ~(pad_ctl_q[4] & pad_ctl_q[0]);
    end

    // Edge qualification against the selected mode.
    always_comb begin
        evt_o = (mode_q[0] & ~sync_q[1] &  sync_q[2]) |
                (mode_q[1] &  sync_q[1] & ~sync_q[2]);
    end

    assign pad_ctl_o  = pad_ctl_q;
    assign edge_ctl_o = {mode_q, sync_q[1]};

    a_r6_off_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == EDGE_OFF) |-> !evt_o);
endmodule

// File: rtl/gpio_irq_bank.sv
// Module: one bank's pending, primary mask and secondary mask bytes and
// the bank interrupt. Assumes write strobes are already address-decoded.
module gpio_irq_bank
    import gpio_edge_ctl_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_pend,
    input  logic                     wr_mask,
    input  logic                     wr_maskx,
    input  logic [7:0]               wdata,
    input  logic [PINS_PER_BANK-1:0] evt,
    output logic [PINS_PER_BANK-1:0] pend_o,
    output logic [PINS_PER_BANK-1:0] mask_o,
    output logic [PINS_PER_BANK-1:0] maskx_o,
    output logic                     irq_o
);
    logic [PINS_PER_BANK-1:0] pend_q, mask_q, maskx_q, clr;

    // Clear vector from a write-one-to-clear access.
    always_comb clr = wr_pend ? wdata[PINS_PER_BANK-1:0] : '0;

    // Pending bits: a new edge outranks a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | evt;
    end

    // Primary and secondary mask storage, both masked at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            maskx_q <= '1;
        end else begin
            if (wr_mask)  mask_q  <= wdata[PINS_PER_BANK-1:0];
            if (wr_maskx) maskx_q <= wdata[PINS_PER_BANK-1:0];
        end
    end

    // Bank interrupt from unmasked pending bits.
    always_comb irq_o = |(pend_q & ~mask_q);

    assign pend_o  = pend_q;
    assign mask_o  = mask_q;
    assign maskx_o = maskx_q;

    a_r7_set_only_by_event: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt)) == '0));
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((pend_q & $past(evt)) == $past(evt)));
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq_o);
    a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pend_q == '0 && mask_q == '1 && maskx_q == '1));
endmodule

// File: rtl/gpio_edge_ctl.sv
// Module: top of the GPIO controller. Decodes the byte register port,
// instantiates pin slices and bank interrupt logic, and registers read data.
// Assumes single-cycle wr_en/rd_en strobes with addr stable in that cycle.
module gpio_edge_ctl
    import gpio_edge_ctl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            addr,
    input  logic [7:0]            wdata,
    input  logic                  wr_en,
    input  logic                  rd_en,
    output logic [7:0]            rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_od,
    output logic [NUM_PINS-1:0]   pad_pull_en,
    output logic [2*NUM_PINS-1:0] pad_pull_sel,
    output logic                  irq
);
    logic [5:0]               pad_ctl  [NUM_PINS];
    logic [2:0]               edge_ctl [NUM_PINS];
    logic [NUM_PINS-1:0]      evt;
    logic [PINS_PER_BANK-1:0] pend  [NUM_BANKS];
    logic [PINS_PER_BANK-1:0] mask  [NUM_BANKS];
    logic [PINS_PER_BANK-1:0] maskx [NUM_BANKS];
    logic [NUM_BANKS-1:0]     bank_irq;
    logic [7:0]               rd_mux;
    logic                     hit;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam logic [7:0] OFS = 8'(p % PINS_PER_BANK) +
                                     BANK_STRIDE * 8'(p / PINS_PER_BANK);
        gpio_pin_slice u_pin (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_pad     (wr_en && addr == PAD_CTL_BASE + OFS),
            .wr_edge    (wr_en && addr == EDGE_CTL_BASE + OFS),
            .wdata      (wdata[5:0]),
            .pad_in     (pad_in[p]),
            .pad_ctl_o  (pad_ctl[p]),
            .edge_ctl_o (edge_ctl[p]),
            .pad_out    (pad_out[p]),
            .pad_oe     (pad_oe[p]),
            .pad_od     (pad_od[p]),
            .pull_en    (pad_pull_en[p]),
            .pull_sel   (pad_pull_sel[2*p+1:2*p]),
            .evt_o      (evt[p])
        );
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_irq_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_pend  (wr_en && addr == PEND_BASE + 8'(b)),
            .wr_mask  (wr_en && addr == MASK_BASE + 8'(b)),
            .wr_maskx (wr_en && addr == MASKX_BASE + 8'(b)),
            .wdata    (wdata),
            .evt      (evt[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .pend_o   (pend[b]),
            .mask_o   (mask[b]),
            .maskx_o  (maskx[b]),
            .irq_o    (bank_irq[b])
        );
    end

    // Combined host interrupt.
    always_comb irq = |bank_irq;

    // Read multiplexer; unmapped addresses yield zero.
    always_comb begin
        rd_mux = '0;
        hit    = 1'b0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (addr == PAD_CTL_BASE + 8'(p % PINS_PER_BANK) +
                        BANK_STRIDE * 8'(p / PINS_PER_BANK)) begin
                rd_mux = {2'b00, pad_ctl[p]};
                hit    = 1'b1;
            end
            if (addr == EDGE_CTL_BASE + 8'(p % PINS_PER_BANK) +
                        BANK_STRIDE * 8'(p / PINS_PER_BANK)) begin
                rd_mux = {5'b00000, edge_ctl[p]};
                hit    = 1'b1;
            end
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == PEND_BASE + 8'(b))  begin rd_mux = 8'(pend[b]);  hit = 1'b1; end
            if (addr == MASK_BASE + 8'(b))  begin rd_mux = 8'(mask[b]);  hit = 1'b1; end
            if (addr == MASKX_BASE + 8'(b)) begin rd_mux = 8'(maskx[b]); hit = 1'b1; end
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |=> (rdata == 8'h00));
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && $past(rst_n)) |=> $stable(rdata));
endmodule

// File: tb/gpio_edge_ctl_bench.sv
`timescale 1ns/100ps
module gpio_edge_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0, wdata = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe, pad_od, pad_pull_en;
    logic [31:0] pad_pull_sel;
    logic        irq;
    int          n_run = 0, n_fail = 0;
    logic [7:0]  rv;

    always #2.5 clk = ~clk;

    gpio_edge_ctl u_gpio_edge_ctl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
        .pad_pull_en(pad_pull_en), .pad_pull_sel(pad_pull_sel), .irq(irq)
    );

    // Register write/readback vectors: {address, write data, expected read}.
    localparam logic [23:0] VEC [10] = '{
        {8'h2B, 8'hFF, 8'h3F},   // R3 pin 0, bits 7:6 read 0
        {8'h32, 8'h15, 8'h15},   // R2 pin 7
        {8'h3B, 8'h2A, 8'h2A},   // R2 pin 8
        {8'h42, 8'h07, 8'h07},   // R2 pin 15
        {8'h36, 8'hFE, 8'h06},   // R4 pin 3 mode readback, level 0
        {8'h4A, 8'h02, 8'h02},   // R4 pin 15
        {8'h1B, 8'h5A, 8'h5A},   // R10 secondary mask bank 0
        {8'h1C, 8'hA5, 8'hA5},   // R10 secondary mask bank 1
        {8'h19, 8'h3C, 8'h3C},   // R9 primary mask bank 0
        {8'h1A, 8'hFF, 8'hFF}    // R9 primary mask bank 1
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Caller is at a negedge; strobe is sampled at the next posedge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #(5ns * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pad_oe", pad_oe, 16'h0);
        chk("R1 irq", irq, 1'b0);
        rd(8'h19, rv); chk("R1 mask0", rv, 8'hFF);
        rd(8'h1C, rv); chk("R1 maskx1", rv, 8'hFF);
        rd(8'h0B, rv); chk("R1 pend0", rv, 8'h00);
        rd(8'h43, rv); chk("R1 mode pin8", rv, 8'h00);

        // R2 R3 R4 R9 R10 register table
        for (int i = 0; i < 10; i++) begin
            wr(VEC[i][23:16], VEC[i][15:8]);
            rd(VEC[i][23:16], rv);
            chk($sformatf("R2 table entry %0d", i), rv, VEC[i][7:0]);
        end
        wr(8'h19, 8'hFF);

        // R3 pad drive decode
        wr(8'h2E, 8'h21); chk("R3 push-pull high oe", pad_oe[3], 1'b1);
        chk("R3 push-pull high out", pad_out[3], 1'b1);
        wr(8'h2E, 8'h31); chk("R3 open-drain high releases", pad_oe[3], 1'b0);
        chk("R3 od flag", pad_od[3], 1'b1);
        wr(8'h2E, 8'h30); chk("R3 open-drain low drives", pad_oe[3], 1'b1);
        wr(8'h3D, 8'h0E); chk("R3 pull enable pin10", pad_pull_en[10], 1'b1);
        chk("R3 pull code pin10", pad_pull_sel[21:20], 2'd3);
        chk("R3 input pin10", pad_oe[10], 1'b0);

        // R4 synchronized level readback
        pad_in[7] = 1'b1; settle();
        rd(8'h3A, rv); chk("R4 level pin7", rv[0], 1'b1);
        pad_in[7] = 1'b0; settle();

        // R5 rising edge, pin 10 -> bank 1 bit 2
        wr(8'h45, 8'h04);
        pad_in[10] = 1'b1; settle();
        rd(8'h0C, rv); chk("R5 rise pin10 pend1", rv, 8'h04);
        rd(8'h0B, rv); chk("R5 bank0 untouched", rv, 8'h00);
        chk("R9 masked no irq", irq, 1'b0);
        wr(8'h1C, 8'h00); chk("R10 secondary mask no effect", irq, 1'b0);
        wr(8'h1A, 8'hFB); chk("R9 unmasked irq", irq, 1'b1);
        wr(8'h0C, 8'hFB); rd(8'h0C, rv); chk("R7 zero bits keep pending", rv, 8'h04);
        chk("R9 irq still level", irq, 1'b1);
        wr(8'h0C, 8'h04); rd(8'h0C, rv); chk("R7 clear", rv, 8'h00);
        chk("R9 irq drops", irq, 1'b0);
        pad_in[10] = 1'b0; settle();
        rd(8'h0C, rv); chk("R5 rise mode ignores fall", rv, 8'h00);

        // R5 falling edge, pin 1
        wr(8'h34, 8'h02);
        pad_in[1] = 1'b1; settle();
        rd(8'h0B, rv); chk("R5 fall mode ignores rise", rv, 8'h00);
        pad_in[1] = 1'b0; settle();
        rd(8'h0B, rv); chk("R5 fall pin1", rv, 8'h02);
        wr(8'h0B, 8'h02);

        // R5 both edges, pin 0
        wr(8'h33, 8'h06);
        pad_in[0] = 1'b1; settle();
        rd(8'h0B, rv); chk("R5 both rise pin0", rv, 8'h01);
        wr(8'h0B, 8'h01);
        pad_in[0] = 1'b0; settle();
        rd(8'h0B, rv); chk("R5 both fall pin0", rv, 8'h01);
        wr(8'h0B, 8'h01);

        // R6 disabled pin toggles
        for (int k = 0; k < 4; k++) begin
            pad_in[5] = ~pad_in[5]; settle();
        end
        rd(8'h0B, rv); chk("R6 disabled no pending", rv, 8'h00);

        // R8 edge in the same cycle as a clear of a set bit
        pad_in[0] = 1'b1; settle();
        rd(8'h0B, rv); chk("R8 precondition", rv, 8'h01);
        pad_in[0] = 1'b0;
        @(negedge clk); @(negedge clk);
        wr(8'h0B, 8'h01);
        rd(8'h0B, rv); chk("R8 edge beats clear", rv, 8'h01);
        wr(8'h0B, 8'h01); rd(8'h0B, rv); chk("R8 later clear works", rv, 8'h00);

        // R11 unmapped reads and hold
        rd(8'h1B, rv);
        rd(8'h00, rv); chk("R11 unmapped 0x00", rv, 8'h00);
        rd(8'h1A, rv); chk("R11 mapped before hold", rv, 8'hFB);
        repeat (3) @(negedge clk);
        chk("R11 rdata holds", rdata, 8'hFB);
        rd(8'h4B, rv); chk("R11 unmapped 0x4B", rv, 8'h00);
        rd(8'hFF, rv); chk("R11 unmapped 0xFF", rv, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule